// File: doc/BRIEF.md
# Pseudo-SRAM Configuration and Sleep-Mode Controller

This block is the device-side control logic of a self-refreshing pseudo-SRAM. It holds an 8-bit configuration word, runs the power-up initialisation wait, follows the active-low sleep-enable pin and moves the device into one of two low-power states. One of these keeps a chosen part of the array refreshed. The other drops all refresh, and leaving it forces a full initialisation again. The block tells the rest of the device whether array access is allowed. It gives the refresh engine an enable and an inclusive address window, and it exposes the page-read enable and the temperature-threshold setting.

The configuration word is written over the address pins. The sleep-enable pin is pulled low, and a write cycle then begins inside a short window of clock cycles. The low address byte is captured when the write ends, which is the first of chip enable or write enable to return high. If the sleep pin instead stays low for more than a set number of microsecond ticks, with no such write, the device goes to sleep. The configuration's sleep-mode bit picks which low-power state is used. All timing is counted in `clk` cycles and in pulses on `us_tick`. The density is set by `ADDR_W`: 21 gives 2M words and 22 gives 4M words.

Top module: `psram_cfg_sleep_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the configuration holds 0x70. In this state `page_en`=0, `temp_sel`=2'b11, `ready`=0, `refresh_en`=1, `rfsh_lo`=0 and `rfsh_hi`=2^ADDR_W-1.
- R2: After reset, and after leaving deep power-down, `ready` stays 0 until INIT_US `us_tick` pulses have been sampled. It is 1 from the cycle after the edge that samples the last of them.
- R3: A write cycle is `chip_en_n`=0 together with `wr_en_n`=0. It loads the configuration when its first sampled cycle is k edges after the edge that first saw `sleep_n`=0, with LD_MIN_CYC ≤ k ≤ LD_MAX_CYC. The value loaded is `addr[7:0]`, captured on the edge where the write ends. Bit 7 drives `page_en`, bits 6:5 drive `temp_sel`, bit 4=1 selects partial-refresh sleep (0 selects deep power-down), and bits 2:0 are the region code.
- R4: A write that starts after LD_MAX_CYC edges, or one that is already in progress when `sleep_n` falls, leaves the configuration unchanged.
- R5: Address bit 3 and bits above 7 are ignored on a load. Only bits 7..4 and 2..0 affect the outputs.
- R6: Outside sleep, `ready`=1 and the full array is refreshed. The device enters sleep on the edge that samples the (SLEEP_MIN_US+1)-th tick of an unbroken `sleep_n`-low period. A shorter low period changes no output.
- R7: In partial-refresh sleep the window depends on the region code, where Q = 2^ADDR_W/4. Code 0 gives [0, 4Q-1], 1 gives [0, 3Q-1], 2 gives [0, 2Q-1] and 3 gives [0, Q-1]. Code 5 gives [Q, 4Q-1], 6 gives [2Q, 4Q-1] and 7 gives [3Q, 4Q-1]. Code 4 gives `refresh_en`=0 with both bounds 0. In every state, `rfsh_lo` ≤ `rfsh_hi` whenever `refresh_en`=1.
- R8: In partial-refresh sleep `ready`=0. When `sleep_n` is sampled high, `ready` returns to 1 in the next cycle.
- R9: In deep power-down, `ready`=0, `refresh_en`=0 and both bounds are 0. When `sleep_n` is sampled high, the initialisation wait of R2 starts again.
- R10: A low period of `sleep_n` in which a configuration write was accepted never leads to sleep, however many ticks follow.
- R11: Write cycles while the device sleeps change no configuration field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| chip_en_n | input | 1 | Chip enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| sleep_n | input | 1 | Sleep-enable pin, active low |
| addr | input | ADDR_W | Address bus; low byte carries the configuration value |
| ready | output | 1 | Array reads and writes are permitted |
| refresh_en | output | 1 | Refresh engine may run |
| rfsh_lo | output | ADDR_W | Lowest word address to refresh |
| rfsh_hi | output | ADDR_W | Highest word address to refresh |
| page_en | output | 1 | Page-mode reads enabled |
| temp_sel | output | 2 | Refresh temperature threshold (11 = hottest) |

## Verification
The assertions assume that all pins are already synchronous to `clk`, that `us_tick` is a single-cycle pulse, and that no tick arrives on the edge at which a configuration write is first accepted. The stimulus drives every input just after the falling clock edge. It spaces ticks four cycles apart, and it never pulses `us_tick` during a configuration write. Random configuration words and random write start offsets are drawn only from inside the accepted window. The out-of-window cases are placed by directed steps at exact edge counts.

// File: rtl/pcsc_pkg.sv
package pcsc_pkg;

    typedef enum logic [2:0] {
        PW_INIT,
        PW_ACTIVE,
        PW_ZZLOW,
        PW_PAR,
        PW_DPD
    } pwr_state_e;

    // bit 7 page, 6:5 temperature, 4 sleep kind, 3 reserved, 2:0 region
    typedef struct packed {
        logic       page_en;
        logic [1:0] temp;
        logic       keep_par;
        logic       rsvd;
        logic [2:0] region;
    } cfg_t;

    localparam cfg_t CFG_RESET = cfg_t'(8'h70);

    // refreshed span in quarters of the array: [lo_q, hi_q)
    typedef struct packed {
        logic       active;
        logic [1:0] lo_q;
        logic [2:0] hi_q;
    } span_t;

    function automatic span_t region_span(input logic [2:0] code);
        span_t s;
        case (code)
            3'd0:    s = '{active: 1'b1, lo_q: 2'd0, hi_q: 3'd4};
            3'd1:    s = '{active: 1'b1, lo_q: 2'd0, hi_q: 3'd3};
            3'd2:    s = '{active: 1'b1, lo_q: 2'd0, hi_q: 3'd2};
            3'd3:    s = '{active: 1'b1, lo_q: 2'd0, hi_q: 3'd1};
            3'd5:    s = '{active: 1'b1, lo_q: 2'd1, hi_q: 3'd4};
            3'd6:    s = '{active: 1'b1, lo_q: 2'd2, hi_q: 3'd4};
            3'd7:    s = '{active: 1'b1, lo_q: 2'd3, hi_q: 3'd4};
            default: s = '{active: 1'b0, lo_q: 2'd0, hi_q: 3'd0};
        endcase
        return s;
    endfunction

    function automatic cfg_t sanitize(input logic [7:0] w);
        cfg_t c;
        c      = cfg_t'(w);
        c.rsvd = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/pcsc_cfg_load.sv
module pcsc_cfg_load
    import pcsc_pkg::*;
#(
    parameter int LD_MIN_CYC = 1,
    parameter int LD_MAX_CYC = 50
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_zz_low,
    input  logic       chip_en_n,
    input  logic       wr_en_n,
    input  logic [7:0] ld_word,
    output cfg_t       cfg_q,
    output logic       ld_block
);

    localparam int WIN_W = $clog2(LD_MAX_CYC + 2);
    localparam logic [WIN_W-1:0] WIN_SAT = WIN_W'(LD_MAX_CYC + 1);
    localparam logic [WIN_W:0]   WIN_LO  = (WIN_W+1)'(LD_MIN_CYC);
    localparam logic [WIN_W:0]   WIN_HI  = (WIN_W+1)'(LD_MAX_CYC);

    logic [WIN_W-1:0] win_cnt;
    logic [WIN_W:0]   elapsed;
    logic wr_now, wr_prev, armed, wr_start, in_win, capture;

    assign wr_now   = !chip_en_n && !wr_en_n;
    assign wr_start = wr_now && !wr_prev;
    assign elapsed  = {1'b0, win_cnt} + (WIN_W+1)'(1);
    assign in_win   = in_zz_low && (elapsed >= WIN_LO) && (elapsed <= WIN_HI);
    assign capture  = armed && !wr_now && in_zz_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt  <= '0;
            wr_prev  <= 1'b0;
            armed    <= 1'b0;
            ld_block <= 1'b0;
            cfg_q    <= CFG_RESET;
        end else begin
            wr_prev <= wr_now;
            if (!in_zz_low)
                win_cnt <= '0;
            else if (win_cnt != WIN_SAT)
                win_cnt <= win_cnt + WIN_W'(1);

            if (capture) begin
                cfg_q <= sanitize(ld_word);
                armed <= 1'b0;
            end else if (wr_start && in_win) begin
                armed <= 1'b1;
            end else if (!in_zz_low) begin
                armed <= 1'b0;
            end

            ld_block <= in_zz_low && (ld_block || (wr_start && in_win));
        end
    end

    // R1
    cfg_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg_q == CFG_RESET);

    // R3
    cfg_only_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_q) |-> $past(in_zz_low));

endmodule

// File: rtl/pcsc_power_fsm.sv
module pcsc_power_fsm
    import pcsc_pkg::*;
#(
    parameter int INIT_US      = 150,
    parameter int SLEEP_MIN_US = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       us_tick,
    input  logic       sleep_n,
    input  logic       keep_par,
    input  logic       ld_block,
    output pwr_state_e state_q
);

    localparam int CNT_MAX = (INIT_US > SLEEP_MIN_US + 1) ? INIT_US : SLEEP_MIN_US + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] INIT_LAST  = CNT_W'(INIT_US - 1);
    localparam logic [CNT_W-1:0] SLEEP_LAST = CNT_W'(SLEEP_MIN_US);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PW_INIT;
            cnt     <= '0;
        end else begin
            case (state_q)
                PW_INIT: begin
                    if (us_tick) begin
                        if (cnt == INIT_LAST) begin
                            state_q <= PW_ACTIVE;
                            cnt     <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                PW_ACTIVE: begin
                    if (!sleep_n) begin
                        state_q <= PW_ZZLOW;
                        cnt     <= '0;
                    end
                end
                PW_ZZLOW: begin
                    if (sleep_n) begin
                        state_q <= PW_ACTIVE;
                        cnt     <= '0;
                    end else if (ld_block) begin
                        cnt <= '0;
                    end else if (us_tick) begin
                        if (cnt == SLEEP_LAST) begin
                            state_q <= keep_par ? PW_PAR : PW_DPD;
                            cnt     <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                PW_PAR: begin
                    if (sleep_n) state_q <= PW_ACTIVE;
                end
                PW_DPD: begin
                    if (sleep_n) begin
                        state_q <= PW_INIT;
                        cnt     <= '0;
                    end
                end
                default: begin
                    state_q <= PW_INIT;
                    cnt     <= '0;
                end
            endcase
        end
    end

    // R2
    init_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PW_INIT && !us_tick) |=> state_q == PW_INIT);

    // R6
    sleep_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PW_ZZLOW && !us_tick) |=> (state_q == PW_ZZLOW || state_q == PW_ACTIVE));

    // R8
    par_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PW_PAR && sleep_n) |=> state_q == PW_ACTIVE);

    // R9
    dpd_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PW_DPD && sleep_n) |=> state_q == PW_INIT);

    // R10
    load_blocks_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PW_ZZLOW && ld_block && !sleep_n) |=> state_q == PW_ZZLOW);

endmodule

// File: rtl/pcsc_refresh_win.sv
module pcsc_refresh_win
    import pcsc_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  pwr_state_e        state,
    input  logic [2:0]        region,
    output logic              refresh_en,
    output logic [ADDR_W-1:0] rfsh_lo,
    output logic [ADDR_W-1:0] rfsh_hi
);

    localparam int QW = ADDR_W - 2;

    span_t sp;
    assign sp = region_span(region);

    always_comb begin
        if (state == PW_PAR && sp.active) begin
            refresh_en = 1'b1;
            rfsh_lo    = {sp.lo_q, {QW{1'b0}}};
            rfsh_hi    = ADDR_W'({sp.hi_q, {QW{1'b0}}} - (ADDR_W+1)'(1));
        end else if (state == PW_PAR || state == PW_DPD) begin
            refresh_en = 1'b0;
            rfsh_lo    = '0;
            rfsh_hi    = '0;
        end else begin
            refresh_en = 1'b1;
            rfsh_lo    = '0;
            rfsh_hi    = '1;
        end
    end

    always_comb begin
        // R7
        if (refresh_en) span_order_chk: assert (rfsh_lo <= rfsh_hi);
    end

endmodule

// File: rtl/psram_cfg_sleep_ctrl.sv
module psram_cfg_sleep_ctrl
    import pcsc_pkg::*;
#(
    parameter int ADDR_W       = 22,
    parameter int INIT_US      = 150,
    parameter int SLEEP_MIN_US = 10,
    parameter int LD_MIN_CYC   = 1,
    parameter int LD_MAX_CYC   = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              us_tick,
    input  logic              chip_en_n,
    input  logic              wr_en_n,
    input  logic              sleep_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic              refresh_en,
    output logic [ADDR_W-1:0] rfsh_lo,
    output logic [ADDR_W-1:0] rfsh_hi,
    output logic              page_en,
    output logic [1:0]        temp_sel
);

    cfg_t       cfg;
    pwr_state_e state;
    logic       ld_block;
    logic       in_zz_low;
    logic       unused_bits;

    assign in_zz_low   = (state == PW_ZZLOW);
    assign unused_bits = ^{addr[ADDR_W-1:8], cfg.rsvd};

    pcsc_cfg_load #(
        .LD_MIN_CYC (LD_MIN_CYC),
        .LD_MAX_CYC (LD_MAX_CYC)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .in_zz_low (in_zz_low),
        .chip_en_n (chip_en_n),
        .wr_en_n   (wr_en_n),
        .ld_word   (addr[7:0]),
        .cfg_q     (cfg),
        .ld_block  (ld_block)
    );

    pcsc_power_fsm #(
        .INIT_US      (INIT_US),
        .SLEEP_MIN_US (SLEEP_MIN_US)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .us_tick  (us_tick),
        .sleep_n  (sleep_n),
        .keep_par (cfg.keep_par),
        .ld_block (ld_block),
        .state_q  (state)
    );

    pcsc_refresh_win #(
        .ADDR_W (ADDR_W)
    ) u_win (
        .state      (state),
        .region     (cfg.region),
        .refresh_en (refresh_en),
        .rfsh_lo    (rfsh_lo),
        .rfsh_hi    (rfsh_hi)
    );

    assign ready    = (state == PW_ACTIVE) || (state == PW_ZZLOW);
    assign page_en  = cfg.page_en;
    assign temp_sel = cfg.temp;

endmodule

// File: tb/psram_cfg_sleep_ctrl_tb.sv
module psram_cfg_sleep_ctrl_tb;

    localparam int AW    = 22;
    localparam int INITN = 150;
    localparam int SMIN  = 10;
    localparam int LDMAX = 50;
    localparam logic [31:0] NW = 32'd1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic us_tick = 1'b0;
    logic chip_en_n = 1'b1;
    logic wr_en_n = 1'b1;
    logic sleep_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic ready, refresh_en, page_en;
    logic [AW-1:0] rfsh_lo, rfsh_hi;
    logic [1:0] temp_sel;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;
    logic [7:0] m_cfg = 8'h70;

    always #5 clk = ~clk;

    psram_cfg_sleep_ctrl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .us_tick(us_tick), .chip_en_n(chip_en_n),
        .wr_en_n(wr_en_n), .sleep_n(sleep_n), .addr(addr), .ready(ready),
        .refresh_en(refresh_en), .rfsh_lo(rfsh_lo), .rfsh_hi(rfsh_hi),
        .page_en(page_en), .temp_sel(temp_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic tick1();
        repeat (3) cyc();
        us_tick = 1'b1;
        cyc();
        us_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) tick1();
    endtask

    // expected sleep window from the region code
    task automatic exp_span(input logic [2:0] code, output logic en,
                            output logic [31:0] lo, output logic [31:0] hi);
        en = 1'b1;
        case (code)
            3'd0: begin lo = 0;            hi = NW - 1;         end
            3'd1: begin lo = 0;            hi = NW / 4 * 3 - 1; end
            3'd2: begin lo = 0;            hi = NW / 2 - 1;     end
            3'd3: begin lo = 0;            hi = NW / 4 - 1;     end
            3'd5: begin lo = NW / 4;       hi = NW - 1;         end
            3'd6: begin lo = NW / 2;       hi = NW - 1;         end
            3'd7: begin lo = NW / 4 * 3;   hi = NW - 1;         end
            default: begin en = 1'b0; lo = 0; hi = 0; end
        endcase
    endtask

    task automatic chk_awake(input string tag);
        chk({tag, " ready"}, {31'd0, ready}, 32'd1);
        chk({tag, " refresh_en"}, {31'd0, refresh_en}, 32'd1);
        chk({tag, " lo"}, 32'(rfsh_lo), 32'd0);
        chk({tag, " hi"}, 32'(rfsh_hi), NW - 1);
    endtask

    task automatic chk_fields(input string tag);
        chk({tag, " page_en"}, {31'd0, page_en}, {31'd0, m_cfg[7]});
        chk({tag, " temp_sel"}, {30'd0, temp_sel}, {30'd0, m_cfg[6:5]});
    endtask

    // write starting k edges after the sleep pin falls; accepted per R3/R4
    task automatic do_load(input logic [AW-1:0] a, input int k, input bit ce_first);
        addr = a;
        sleep_n = 1'b0;
        if (k == 0) begin
            chip_en_n = 1'b0; wr_en_n = 1'b0;
        end else begin
            repeat (k) cyc();
            chip_en_n = 1'b0; wr_en_n = 1'b0;
        end
        repeat (3) cyc();
        if (ce_first) chip_en_n = 1'b1; else wr_en_n = 1'b1;
        cyc();
        chip_en_n = 1'b1; wr_en_n = 1'b1;
        sleep_n = 1'b1;
        cyc();
        cyc();
        if (k >= 1 && k <= LDMAX) m_cfg = {a[7:4], 1'b0, a[2:0]};
    endtask

    // full sleep entry, check, exit and (for deep power-down) re-init
    task automatic sleep_cycle(input string tag);
        logic en;
        logic [31:0] lo, hi;
        sleep_n = 1'b0;
        ticks(SMIN);
        chk_awake({tag, " R6 before threshold"});
        tick1();
        chk({tag, " R6 asleep ready"}, {31'd0, ready}, 32'd0);
        if (m_cfg[4]) begin
            exp_span(m_cfg[2:0], en, lo, hi);
            chk({tag, " R7 refresh_en"}, {31'd0, refresh_en}, {31'd0, en});
            chk({tag, " R7 lo"}, 32'(rfsh_lo), lo);
            chk({tag, " R7 hi"}, 32'(rfsh_hi), hi);
            sleep_n = 1'b1;
            cyc();
            chk({tag, " R8 exit ready"}, {31'd0, ready}, 32'd1);
        end else begin
            chk({tag, " R9 refresh_en"}, {31'd0, refresh_en}, 32'd0);
            chk({tag, " R9 hi"}, 32'(rfsh_hi), 32'd0);
            sleep_n = 1'b1;
            cyc();
            chk({tag, " R9 exit not ready"}, {31'd0, ready}, 32'd0);
            ticks(INITN - 1);
            chk({tag, " R9 reinit pending"}, {31'd0, ready}, 32'd0);
            tick1();
            chk({tag, " R9 reinit done"}, {31'd0, ready}, 32'd1);
        end
        chk_fields({tag, " fields after wake"});
    endtask

    initial begin
        void'($urandom(32'h5A17C3E9));
        repeat (3) cyc();
        chk("R1 ready in reset", {31'd0, ready}, 32'd0);
        chk("R1 page_en", {31'd0, page_en}, 32'd0);
        chk("R1 temp_sel", {30'd0, temp_sel}, 32'd3);
        chk("R1 refresh_en", {31'd0, refresh_en}, 32'd1);
        chk("R1 hi", 32'(rfsh_hi), NW - 1);
        rst = 1'b0;
        cyc();
        chk_fields("R1 after release");
        ticks(INITN - 1);
        chk("R2 not ready yet", {31'd0, ready}, 32'd0);
        tick1();
        chk("R2 ready", {31'd0, ready}, 32'd1);
        chk_awake("R6 awake");

        // R3 and R5: minimum offset, reserved bit and high bits set
        do_load(22'h3FFF9E, 1, 1'b0);
        chk_fields("R3 R5 load at min offset");

        // R11: write while in partial sleep
        sleep_n = 1'b0;
        ticks(SMIN + 1);
        chk("R7 top-half lo", 32'(rfsh_lo), NW / 2);
        chk("R7 top-half hi", 32'(rfsh_hi), NW - 1);
        addr = '0; chip_en_n = 1'b0; wr_en_n = 1'b0;
        repeat (3) cyc();
        chip_en_n = 1'b1; wr_en_n = 1'b1;
        cyc();
        sleep_n = 1'b1;
        cyc();
        chk("R8 ready after partial exit", {31'd0, ready}, 32'd1);
        chk_fields("R11 write while asleep");

        // R4: already-running write, and a write one edge too late
        do_load(22'h000000, 0, 1'b0);
        chk_fields("R4 write before fall");
        do_load(22'h000000, LDMAX + 1, 1'b1);
        chk_fields("R4 write too late");
        do_load(22'h000064, LDMAX, 1'b1);
        chk_fields("R3 load at max offset");

        // R6: short pulse changes nothing
        sleep_n = 1'b0;
        ticks(SMIN);
        sleep_n = 1'b1;
        cyc();
        chk_awake("R6 short pulse");
        chk_fields("R6 short pulse fields");

        // R10: accepted load then long low period
        addr = 22'h000013;
        sleep_n = 1'b0;
        repeat (2) cyc();
        chip_en_n = 1'b0; wr_en_n = 1'b0;
        repeat (2) cyc();
        wr_en_n = 1'b1;
        cyc();
        chip_en_n = 1'b1;
        m_cfg = 8'h13;
        ticks(SMIN + 3);
        chk("R10 no sleep after load", {31'd0, ready}, 32'd1);
        sleep_n = 1'b1;
        cyc();
        chk_fields("R10 loaded fields");

        sleep_cycle("bottom-quarter");
        do_load(22'h000060, 5, 1'b0);
        sleep_cycle("deep");
        do_load(22'h0000D4, 7, 1'b1);
        sleep_cycle("none-region");

        for (int i = 0; i < 12; i++) begin
            logic [AW-1:0] a;
            int k;
            a = AW'($urandom);
            k = 1 + int'($urandom % LDMAX);
            do_load(a, k, 1'($urandom));
            chk_fields("R3 random load");
            sleep_cycle("random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule